// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time over a single-port memory interface that uses a request/acknowledge handshake. The caller supplies a base register value, a signed 16-bit displacement, a source register value, the current value of register 0, an 8-bit operation selector and an access width of 32 or 64 bits. The unit forms the effective address and reads the addressed location. It computes the new value, writes it back, and then returns the prior memory contents together with flags that say which registers the caller must update.

The operation selector picks one of four simple updates: add, bitwise or, bitwise and, or bitwise exclusive-or. Each can optionally fetch the old value into the source register. The selector can also pick an exchange or a compare-and-exchange. A compare-and-exchange uses register 0 for both the comparison and the result. While the operation runs, the unit holds a lock output so that no other agent can get between its read and its write. The unit rejects an unknown selector or a misaligned address before it touches memory.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req`, `mem_lock` and `rsp_valid` are 0. A request is taken only while `req_ready` is 1, and `req_ready` stays 0 from acceptance until the response cycle has ended.
- R2: The memory address equals `req_base` plus `req_offset` sign-extended to the address width. The same address is used for both the read and the write.
- R3: Selector codes 0x00, 0x40, 0x50 and 0xa0 (bit 0 clear) store old+src, old|src, old&src and old^src. With `req_dword`=1 the operation works on 64 bits. With `req_dword`=0 it works on the low 32 bits of the source, with the sum wrapping at 32 bits; word data travels in bits 31:0 of the memory data buses.
- R4: Selector bit 0 (value 0x01) asks for a fetch. For a simple operation with fetch, the response has `rsp_wr_src`=1 and `rsp_old` set to the prior memory value, zero-extended for a word. Without fetch, `rsp_wr_src`=0 and memory is still updated.
- R5: Selector 0xe1 (exchange) stores the source value, and the response has `rsp_wr_src`=1 with `rsp_old` set to the prior value.
- R6: Selector 0xf1 (compare-and-exchange) compares the prior value with `req_r0`, using only the low 32 bits for a word. On a match it stores the source value. On a mismatch it makes no write. In both cases the response has `rsp_wr_r0`=1, `rsp_wr_src`=0 and `rsp_old` set to the zero-extended prior value.
- R7: Any other selector value, including 0xe0 and 0xf0, gives `rsp_err_illegal`=1 in the cycle right after acceptance. It makes no memory access and leaves both register-write flags at 0.
- R8: For a word access the address bits 1:0 must be zero, and for a doubleword access bits 2:0 must be zero. A misaligned address gives `rsp_err_align`=1 with no memory access and no register write. When a request is both illegal and misaligned, only `rsp_err_illegal` is set.
- R9: `mem_lock` is 1 whenever `mem_req` is 1. It stays 1 without a break from the read request, through the modify cycle, to the write acknowledge, and it is 0 in idle and in the response cycle.
- R10: Once raised, a memory request keeps `mem_addr`, `mem_we`, `mem_wdata` and `mem_dword` stable until `mem_ack` is seen. The read always comes before the write.
- R11: `rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request accepted this cycle if valid |
| req_op | input | 8 | Operation selector |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | OFF_W | Signed displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register 0 value (comparand) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_dword | output | 1 | Access width of the memory request |
| mem_wdata | output | 64 | Write data (word in bits 31:0) |
| mem_lock | output | 1 | Memory port locked for the atomic sequence |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 64 | Read data (word in bits 31:0) |
| rsp_valid | output | 1 | Response pulse |
| rsp_old | output | 64 | Prior memory value, zero-extended |
| rsp_wr_src | output | 1 | Caller must write rsp_old into the source register |
| rsp_wr_r0 | output | 1 | Caller must write rsp_old into register 0 |
| rsp_err_illegal | output | 1 | Unknown operation selector |
| rsp_err_align | output | 1 | Misaligned effective address |

## Verification
The bench goes after the word-width corner cases. A word add that crosses 32 bits must wrap and must leave the other half of the doubleword alone; a design that used 64-bit arithmetic would carry into that half. A word compare must ignore the upper bits of register 0; a design that compared all 64 bits would report a false mismatch. A compare mismatch must produce no write at all, while the prior value is still handed back; a design that always wrote would corrupt memory.

Rejected requests are checked by counting memory accesses. The complex selectors without the fetch bit must be rejected, and a request that is both illegal and misaligned must report only the illegal flag. A negative displacement catches a missing sign extension. A slow memory model catches a design that lets its request change before the acknowledge, or that drops the lock between its read and its write.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  localparam int DW = 64;
  localparam int WW = 32;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CMPX
  } amo_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_MODIFY, S_WRITE, S_RESPOND
  } amo_state_e;

  localparam logic [7:0] SEL_ADD   = 8'h00;
  localparam logic [7:0] SEL_OR    = 8'h40;
  localparam logic [7:0] SEL_AND   = 8'h50;
  localparam logic [7:0] SEL_XOR   = 8'ha0;
  localparam logic [7:0] SEL_XCHG  = 8'he1;
  localparam logic [7:0] SEL_CMPX  = 8'hf1;
  localparam logic [7:0] SEL_FETCH = 8'h01;

  // Keep the full value for a doubleword, the zero-extended low half for a word.
  function automatic logic [DW-1:0] f_lane(input logic [DW-1:0] v, input logic dword);
    return dword ? v : {{(DW-WW){1'b0}}, v[WW-1:0]};
  endfunction

  // New memory contents for a given operation kind.
  function automatic logic [DW-1:0] f_combine(input amo_kind_e kind, input logic dword,
                                               input logic [DW-1:0] old,
                                               input logic [DW-1:0] src);
    logic [DW-1:0] r;
    case (kind)
      K_ADD:   r = old + src;
      K_OR:    r = old | src;
      K_AND:   r = old & src;
      K_XOR:   r = old ^ src;
      default: r = src;
    endcase
    return f_lane(r, dword);
  endfunction

  // Comparison for compare-and-exchange at the selected width.
  function automatic logic f_same(input logic dword, input logic [DW-1:0] old,
                                  input logic [DW-1:0] cmp);
    return f_lane(old, dword) == f_lane(cmp, dword);
  endfunction

  function automatic logic f_misaligned(input logic dword, input logic [2:0] lo);
    return dword ? (lo != 3'b000) : (lo[1:0] != 2'b00);
  endfunction

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic [7:0]        op,
  input  logic              dword,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output amo_kind_e         kind,
  output logic              fetch,
  output logic              illegal,
  output logic              misaligned,
  output logic [ADDR_W-1:0] eff_addr
);

  localparam int EXT_W = ADDR_W - OFF_W;

  assign eff_addr   = base + {{EXT_W{off[OFF_W-1]}}, off};
  assign misaligned = f_misaligned(dword, eff_addr[2:0]);
  assign fetch      = (op & SEL_FETCH) != 8'h00;

  always_comb begin
    kind    = K_ADD;
    illegal = 1'b0;
    case (op)
      SEL_ADD, SEL_ADD | SEL_FETCH: kind = K_ADD;
      SEL_OR,  SEL_OR  | SEL_FETCH: kind = K_OR;
      SEL_AND, SEL_AND | SEL_FETCH: kind = K_AND;
      SEL_XOR, SEL_XOR | SEL_FETCH: kind = K_XOR;
      SEL_XCHG:                     kind = K_XCHG;
      SEL_CMPX:                     kind = K_CMPX;
      default:                      illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
(
  input  amo_kind_e     kind,
  input  logic          dword,
  input  logic [DW-1:0] old,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] cmp,
  output logic [DW-1:0] new_val,
  output logic          cmp_hit
);

  assign new_val = f_combine(kind, dword, old, src);
  assign cmp_hit = f_same(dword, old, cmp);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_op,
  input  logic              req_dword,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_r0,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dword,
  output logic [63:0]       mem_wdata,
  output logic              mem_lock,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_old,
  output logic              rsp_wr_src,
  output logic              rsp_wr_r0,
  output logic              rsp_err_illegal,
  output logic              rsp_err_align
);

  amo_state_e        st;
  amo_kind_e         dec_kind, r_kind;
  logic              dec_fetch, dec_illegal, dec_mis;
  logic [ADDR_W-1:0] dec_addr, r_addr;
  logic              r_fetch, r_dword, r_ill, r_mis;
  logic [DW-1:0]     r_src, r_r0, r_old, r_new;
  logic [DW-1:0]     alu_new;
  logic              alu_hit;

  // Named internal events for the checker.
  logic ev_accept, ev_read_done, ev_write_done, ev_cmp_miss;

  atomic_rmw_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .op         (req_op),
    .dword      (req_dword),
    .base       (req_base),
    .off        (req_offset),
    .kind       (dec_kind),
    .fetch      (dec_fetch),
    .illegal    (dec_illegal),
    .misaligned (dec_mis),
    .eff_addr   (dec_addr)
  );

  atomic_rmw_alu u_alu (
    .kind    (r_kind),
    .dword   (r_dword),
    .old     (r_old),
    .src     (r_src),
    .cmp     (r_r0),
    .new_val (alu_new),
    .cmp_hit (alu_hit)
  );

  assign ev_accept     = (st == S_IDLE) && req_valid;
  assign ev_read_done  = (st == S_READ) && mem_ack;
  assign ev_write_done = (st == S_WRITE) && mem_ack;
  assign ev_cmp_miss   = (st == S_MODIFY) && (r_kind == K_CMPX) && !alu_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_kind  <= K_ADD;
      r_addr  <= '0;
      r_fetch <= 1'b0;
      r_dword <= 1'b0;
      r_ill   <= 1'b0;
      r_mis   <= 1'b0;
      r_src   <= '0;
      r_r0    <= '0;
      r_old   <= '0;
      r_new   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ev_accept) begin
            r_kind  <= dec_kind;
            r_addr  <= dec_addr;
            r_fetch <= dec_fetch;
            r_dword <= req_dword;
            r_src   <= req_src;
            r_r0    <= req_r0;
            r_old   <= '0;
            r_ill   <= dec_illegal;
            r_mis   <= dec_mis && !dec_illegal;
            st      <= (dec_illegal || dec_mis) ? S_RESPOND : S_READ;
          end
        end
        S_READ: begin
          if (ev_read_done) begin
            r_old <= f_lane(mem_rdata, r_dword);
            st    <= S_MODIFY;
          end
        end
        S_MODIFY: begin
          r_new <= alu_new;
          st    <= ev_cmp_miss ? S_RESPOND : S_WRITE;
        end
        S_WRITE: begin
          if (ev_write_done) st <= S_RESPOND;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic rsp_ok;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_lock  = (st == S_READ) || (st == S_MODIFY) || (st == S_WRITE);
  assign mem_addr  = r_addr;
  assign mem_dword = r_dword;
  assign mem_wdata = r_new;

  assign rsp_valid       = (st == S_RESPOND);
  assign rsp_ok          = rsp_valid && !r_ill && !r_mis;
  assign rsp_old         = r_old;
  assign rsp_wr_src      = rsp_ok && r_fetch && (r_kind != K_CMPX);
  assign rsp_wr_r0       = rsp_ok && (r_kind == K_CMPX);
  assign rsp_err_illegal = rsp_valid && r_ill;
  assign rsp_err_align   = rsp_valid && r_mis;

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dword,
  input logic [63:0]       mem_wdata,
  input logic              mem_lock,
  input logic              mem_ack,
  input logic              rsp_valid,
  input logic              rsp_wr_src,
  input logic              rsp_wr_r0,
  input logic              rsp_err_illegal,
  input logic              rsp_err_align,
  input logic              ev_read_done,
  input logic              ev_write_done,
  input logic              ev_cmp_miss
);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock || rsp_valid) |-> !req_ready);

  a_r9_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r9_read_holds_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_done |=> (mem_lock && !mem_req));

  a_r9_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_done |=> (rsp_valid && !mem_lock));

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_dword)));

  a_r8_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_dword ? (mem_addr[2:0] == 3'b000) : (mem_addr[1:0] == 2'b00)));

  a_r8_illegal_first: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_align |-> !rsp_err_illegal);

  a_r7_error_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_err_illegal || rsp_err_align)) |-> $past(req_valid && req_ready));

  a_r6_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_miss |=> (rsp_valid && !mem_req));

  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_src || rsp_wr_r0) |-> (rsp_valid && !(rsp_wr_src && rsp_wr_r0)));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_addr        (mem_addr),
  .mem_dword       (mem_dword),
  .mem_wdata       (mem_wdata),
  .mem_lock        (mem_lock),
  .mem_ack         (mem_ack),
  .rsp_valid       (rsp_valid),
  .rsp_wr_src      (rsp_wr_src),
  .rsp_wr_r0       (rsp_wr_r0),
  .rsp_err_illegal (rsp_err_illegal),
  .rsp_err_align   (rsp_err_align),
  .ev_read_done    (ev_read_done),
  .ev_write_done   (ev_write_done),
  .ev_cmp_miss     (ev_cmp_miss)
);

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_op = 8'h00;
  logic        req_dword = 1'b0;
  logic [63:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [63:0] req_src = '0;
  logic [63:0] req_r0 = '0;
  logic        mem_req, mem_we, mem_dword, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid, rsp_wr_src, rsp_wr_r0, rsp_err_illegal, rsp_err_align;
  logic [63:0] rsp_old;

  always #4 clk = ~clk;

  atomic_rmw_unit u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_dword(req_dword), .req_base(req_base), .req_offset(req_offset),
    .req_src(req_src), .req_r0(req_r0),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_dword(mem_dword),
    .mem_wdata(mem_wdata), .mem_lock(mem_lock), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_wr_src(rsp_wr_src),
    .rsp_wr_r0(rsp_wr_r0), .rsp_err_illegal(rsp_err_illegal), .rsp_err_align(rsp_err_align)
  );

  int n_chk = 0;
  int n_err = 0;

  // Memory model state
  logic [63:0] mem_arr [0:15];
  int          lat = 0;
  int          wait_n = 0;
  logic [63:0] hold_addr, hold_wdata;
  logic        hold_we;
  int          n_rd = 0, n_wr = 0, order_bad = 0, stab_bad = 0;
  logic [63:0] rd_addr = '0, wr_addr = '0;
  int          lock_bad = 0, modify_cycles = 0;

  // Captured response
  logic [63:0] c_old;
  logic        c_wsrc, c_wr0, c_ill, c_mis, c_seen;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && !mem_lock) lock_bad++;
      if ((rsp_valid || !req_ready) && !mem_lock && !rsp_valid) lock_bad++;
      if (req_ready && mem_lock) lock_bad++;
      if (rsp_valid && mem_lock) lock_bad++;
      if (mem_lock && !mem_req) modify_cycles++;
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_n == 0) begin
        hold_addr = mem_addr; hold_we = mem_we; hold_wdata = mem_wdata;
      end else if (mem_addr !== hold_addr || mem_we !== hold_we || mem_wdata !== hold_wdata) begin
        stab_bad++;
      end
      if (wait_n < lat) begin
        wait_n++;
      end else begin
        wait_n = 0;
        if (mem_we) begin
          n_wr++;
          wr_addr = mem_addr;
          if (n_rd == 0) order_bad++;
          if (mem_dword) mem_arr[mem_addr[6:3]] = mem_wdata;
          else if (mem_addr[2]) mem_arr[mem_addr[6:3]][63:32] = mem_wdata[31:0];
          else mem_arr[mem_addr[6:3]][31:0] = mem_wdata[31:0];
        end else begin
          n_rd++;
          rd_addr = mem_addr;
          if (mem_dword) mem_rdata = mem_arr[mem_addr[6:3]];
          else if (mem_addr[2]) mem_rdata = {32'h0, mem_arr[mem_addr[6:3]][63:32]};
          else mem_rdata = {32'h0, mem_arr[mem_addr[6:3]][31:0]};
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic do_op(input logic [7:0] op, input logic dw, input logic [63:0] base,
                       input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0);
    int guard;
    @(negedge clk);
    n_rd = 0; n_wr = 0; modify_cycles = 0;
    req_op = op; req_dword = dw; req_base = base; req_offset = off;
    req_src = src; req_r0 = r0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    c_seen = rsp_valid;
    c_old = rsp_old; c_wsrc = rsp_wr_src; c_wr0 = rsp_wr_r0;
    c_ill = rsp_err_illegal; c_mis = rsp_err_align;
    @(negedge clk);
    chk("R11 response pulse ends", {63'h0, rsp_valid}, 64'h0);
    chk("R1 ready after response", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {63'h0, req_ready}, 64'h1);
    chk("R1 reset mem_req", {63'h0, mem_req}, 64'h0);
    chk("R1 reset lock", {63'h0, mem_lock}, 64'h0);
    chk("R1 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic t_simple(input logic [7:0] sel, input logic [63:0] old, input logic [63:0] src,
                          input logic [63:0] exp, input string tag);
    mem_arr[2] = old;
    do_op(sel | 8'h01, 1'b1, 64'h8, 16'h0008, src, 64'h0);
    chk({"R3 ", tag, " memory"}, mem_arr[2], exp);
    chk({"R4 ", tag, " fetch flag"}, {63'h0, c_wsrc}, 64'h1);
    chk({"R4 ", tag, " old value"}, c_old, old);
    chk({"R2 ", tag, " address"}, wr_addr, 64'h10);
  endtask

  task automatic t_word_add_nofetch;
    mem_arr[4] = 64'hFFFF_FFFE_AAAA_5555;
    do_op(8'h00, 1'b0, 64'h20, 16'h0004, 64'h7777_7777_0000_0003, 64'h0);
    chk("R3 word add wraps, low half kept", mem_arr[4], 64'h0000_0001_AAAA_5555);
    chk("R4 no fetch flag", {63'h0, c_wsrc}, 64'h0);
    chk("R4 no r0 flag", {63'h0, c_wr0}, 64'h0);
    chk("R10 one read one write", {32'(n_rd), 32'(n_wr)}, {32'd1, 32'd1});
    chk("R9 lock held in modify", {63'h0, modify_cycles > 0}, 64'h1);
  endtask

  task automatic t_word_xor_fetch;
    mem_arr[5] = 64'h1357_9BDF_8000_00F0;
    do_op(8'ha1, 1'b0, 64'h28, 16'h0000, 64'hFFFF_FFFF_0000_0FF0, 64'h0);
    chk("R3 word xor", mem_arr[5], 64'h1357_9BDF_8000_0F00);
    chk("R4 word fetch zero-extended", c_old, 64'h0000_0000_8000_00F0);
    chk("R4 word fetch flag", {63'h0, c_wsrc}, 64'h1);
  endtask

  task automatic t_xchg;
    mem_arr[6] = 64'hDEAD_BEEF_0BAD_F00D;
    do_op(8'he1, 1'b1, 64'h30, 16'h0000, 64'h0123_4567_89AB_CDEF, 64'h5);
    chk("R5 exchange stores source", mem_arr[6], 64'h0123_4567_89AB_CDEF);
    chk("R5 exchange old", c_old, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R5 exchange src flag", {62'h0, c_wsrc, c_wr0}, 64'h2);
  endtask

  task automatic t_cmpx;
    mem_arr[7] = 64'h1111_2222_3333_4444;
    do_op(8'hf1, 1'b1, 64'h38, 16'h0000, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444);
    chk("R6 dword match stores", mem_arr[7], 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R6 dword match old", c_old, 64'h1111_2222_3333_4444);
    chk("R6 flags r0 only", {62'h0, c_wsrc, c_wr0}, 64'h1);
    mem_arr[8] = 64'h5555_6666_7777_8888;
    do_op(8'hf1, 1'b0, 64'h40, 16'h0000, 64'h0000_0000_0000_0099, 64'h0000_0000_7777_8889);
    chk("R6 word mismatch keeps memory", mem_arr[8], 64'h5555_6666_7777_8888);
    chk("R6 word mismatch no write", {32'(n_rd), 32'(n_wr)}, {32'd1, 32'd0});
    chk("R6 word mismatch old to r0", c_old, 64'h0000_0000_7777_8888);
    chk("R6 mismatch r0 flag", {63'h0, c_wr0}, 64'h1);
    do_op(8'hf1, 1'b0, 64'h44, 16'h0000, 64'hFFFF_FFFF_0000_0042, 64'hBEEF_0000_5555_6666);
    chk("R6 word match ignores upper r0", mem_arr[8], 64'h0000_0042_7777_8888);
    chk("R6 word match old", c_old, 64'h0000_0000_5555_6666);
  endtask

  task automatic t_neg_offset;
    mem_arr[9] = 64'h10;
    do_op(8'h01, 1'b1, 64'h58, 16'hFFF0, 64'h5, 64'h0);
    chk("R2 negative offset read addr", rd_addr, 64'h48);
    chk("R2 negative offset write addr", wr_addr, 64'h48);
    chk("R3 add at negative offset", mem_arr[9], 64'h15);
  endtask

  task automatic t_illegal(input logic [7:0] sel);
    do_op(sel, 1'b1, 64'h10, 16'h0000, 64'h1, 64'h0);
    chk("R7 illegal flag", {62'h0, c_ill, c_mis}, 64'h2);
    chk("R7 no memory access", {32'(n_rd), 32'(n_wr)}, 64'h0);
    chk("R7 no register write", {62'h0, c_wsrc, c_wr0}, 64'h0);
  endtask

  task automatic t_align(input logic dw, input logic [63:0] base, input logic [7:0] sel,
                         input logic [1:0] exp_flags, input string tag);
    do_op(sel, dw, base, 16'h0000, 64'h1, 64'h0);
    chk({"R8 ", tag, " flags"}, {62'h0, c_ill, c_mis}, {62'h0, exp_flags});
    chk({"R8 ", tag, " no access"}, {32'(n_rd), 32'(n_wr)}, 64'h0);
    chk({"R8 ", tag, " no register write"}, {62'h0, c_wsrc, c_wr0}, 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_arr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    lat = 0;
    t_simple(8'h00, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0000_0002_0000_0000, "add");
    t_simple(8'h40, 64'h0000_0000_0000_00F0, 64'h0F00_0000_0000_000F, 64'h0F00_0000_0000_00FF, "or");
    lat = 3;
    t_simple(8'h50, 64'hFF00_FF00_1234_5678, 64'h0FF0_0FF0_FFFF_0000, 64'h0F00_0F00_1234_0000, "and");
    t_simple(8'ha0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_5555_AAAA, "xor");
    t_word_add_nofetch();
    lat = 1;
    t_word_xor_fetch();
    t_xchg();
    t_cmpx();
    lat = 2;
    t_neg_offset();
    t_illegal(8'he0);
    t_illegal(8'hf0);
    t_illegal(8'h10);
    t_align(1'b0, 64'h4A, 8'h01, 2'b01, "word misaligned");
    t_align(1'b1, 64'h54, 8'he1, 2'b01, "dword misaligned");
    t_align(1'b0, 64'h4A, 8'h02, 2'b10, "illegal over misaligned");
    chk("R9 lock discipline", 64'(lock_bad), 64'h0);
    chk("R10 request stable until ack", 64'(stab_bad), 64'h0);
    chk("R10 read before write", 64'(order_bad), 64'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule